// File: doc/BRIEF.md
# Mode-Steered DMA Request and Acknowledge Router

This block sits between an external DMA controller and three byte-wide ports inside an image coding engine: the output FIFO of the encoder, the input FIFO of the decoder, and a one-byte buffer register that carries data between the system bus and the image bus. A two-bit operating mode selects which of these ports is being served. From that port's status flag the block raises a DMA request. When the controller answers with its active-low acknowledge, the block routes the access to the port that the mode selects, as a single-cycle read or write strobe.

The block does not hold the FIFO storage and does not run the coding algorithms. It only decides when to ask for a transfer and where the granted transfer goes. The external rule says chip select and DMA acknowledge must never be low together. The block enforces that rule by discarding any such access and by latching a sticky error flag that only reset clears.

Top module: `dma_mode_steer`

## Requirements
- R1: While reset is high, and in the first cycle after it, the request, all four strobes and the conflict flag are low.
- R2: Mode code 1 (coding) sets the request in the cycle after the encoder FIFO flag reports at least one stored byte. The request clears in the cycle after that flag goes low.
- R3: Mode code 2 (decoding) sets the request in the cycle after the decoder FIFO flag reports at least one free byte. The request clears in the cycle after that flag goes low.
- R4: Mode code 3 (transfer) sets the request in the cycle after the buffer-ready flag is high. The request clears in the cycle after that flag goes low.
- R5: In mode code 0 (idle), the request is low in the cycle after every idle cycle, and an acknowledge produces no strobe.
- R6: A high-to-low change of the acknowledge, sampled at a clock edge, produces a strobe in the next cycle. In coding mode the strobe is the encoder read. In decoding mode it is the decoder write. In transfer mode it is the buffer read when the direction input is 0, and the buffer write when the direction input is 1.
- R7: Each acknowledge assertion gives exactly one strobe pulse, one cycle long, however many cycles the acknowledge stays low.
- R8: If chip select and acknowledge are sampled low at the same edge, no strobe results, and the conflict flag rises in the next cycle. The flag then stays high until reset, while later legal accesses still work.
- R9: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode: 0 idle, 1 coding, 2 decoding, 3 transfer |
| buf_dir_i | input | 1 | Transfer direction: 1 writes into the buffer register, 0 reads from it |
| enc_has_data_i | input | 1 | Encoder output FIFO holds at least one byte |
| dec_has_space_i | input | 1 | Decoder input FIFO has at least one free byte |
| buf_ready_i | input | 1 | Buffer register is ready for the transfer |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| cs_n_i | input | 1 | Processor chip select, active low |
| dreq_o | output | 1 | Registered DMA request |
| enc_rd_o | output | 1 | Read strobe to the encoder output FIFO |
| dec_wr_o | output | 1 | Write strobe to the decoder input FIFO |
| buf_rd_o | output | 1 | Read strobe to the buffer register |
| buf_wr_o | output | 1 | Write strobe to the buffer register |
| conflict_o | output | 1 | Sticky flag for an acknowledge that met chip select |

## Verification
The assertions assume that the mode and direction inputs are stable at the edge where an acknowledge is first sampled low. They also assume that status flags and strobes are judged against values sampled one edge earlier. The stimulus changes every input only on the falling clock edge, so each value is settled at the rising edge that samples it. Each acknowledge is released and held high for at least two cycles before the next one, so every assertion is a separate edge. Chip select is pulled low only in the one deliberate conflict scenario and in no other place.

// File: rtl/dma_mode_steer_pkg.sv
package dma_mode_steer_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_CODE   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_XFER   = 2'd3
  } op_mode_e;

  localparam int NUM_PORTS = 4;
  localparam int PORT_W    = $clog2(NUM_PORTS);

  localparam logic [PORT_W-1:0] PORT_ENC_RD = 2'd0;
  localparam logic [PORT_W-1:0] PORT_DEC_WR = 2'd1;
  localparam logic [PORT_W-1:0] PORT_BUF_RD = 2'd2;
  localparam logic [PORT_W-1:0] PORT_BUF_WR = 2'd3;

endpackage

// File: rtl/dma_mode_steer_req.sv
module dma_mode_steer_req
  import dma_mode_steer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  op_mode_e mode,
  input  logic     enc_has_data,
  input  logic     dec_has_space,
  input  logic     buf_ready,
  output logic     dreq
);

  logic want;

  always_comb begin
    unique case (mode)
      MODE_CODE:   want = enc_has_data;
      MODE_DECODE: want = dec_has_space;
      MODE_XFER:   want = buf_ready;
      default:     want = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dreq <= 1'b0;
    else     dreq <= want;
  end

endmodule

// File: rtl/dma_mode_steer_ack.sv
module dma_mode_steer_ack (
  input  logic clk,
  input  logic rst,
  input  logic dack_n,
  input  logic cs_n,
  output logic accept,
  output logic conflict
);

  logic dack_n_q;
  logic ack_edge;
  logic clash;

  assign ack_edge = dack_n_q && !dack_n;
  assign clash    = !dack_n && !cs_n;
  assign accept   = ack_edge && !clash;

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_n_q <= 1'b1;
      conflict <= 1'b0;
    end else begin
      dack_n_q <= dack_n;
      if (clash) conflict <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_mode_steer_route.sv
module dma_mode_steer_route
  import dma_mode_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  op_mode_e             mode,
  input  logic                 buf_dir,
  input  logic                 accept,
  output logic [NUM_PORTS-1:0] strobe
);

  logic              sel_valid;
  logic [PORT_W-1:0] sel_port;

  always_comb begin
    sel_valid = 1'b1;
    sel_port  = PORT_ENC_RD;
    unique case (mode)
      MODE_CODE:   sel_port = PORT_ENC_RD;
      MODE_DECODE: sel_port = PORT_DEC_WR;
      MODE_XFER:   sel_port = buf_dir ? PORT_BUF_WR : PORT_BUF_RD;
      default:     sel_valid = 1'b0;
    endcase
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) strobe[p] <= 1'b0;
      else     strobe[p] <= accept && sel_valid && (sel_port == PORT_W'(p));
    end
  end

endmodule

// File: rtl/dma_mode_steer.sv
module dma_mode_steer
  import dma_mode_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       buf_dir_i,
  input  logic       enc_has_data_i,
  input  logic       dec_has_space_i,
  input  logic       buf_ready_i,
  input  logic       dack_n_i,
  input  logic       cs_n_i,
  output logic       dreq_o,
  output logic       enc_rd_o,
  output logic       dec_wr_o,
  output logic       buf_rd_o,
  output logic       buf_wr_o,
  output logic       conflict_o
);

  op_mode_e             mode;
  logic                 accept;
  logic [NUM_PORTS-1:0] strobe;

  assign mode = op_mode_e'(mode_i);

  dma_mode_steer_req u_req (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .enc_has_data (enc_has_data_i),
    .dec_has_space(dec_has_space_i),
    .buf_ready    (buf_ready_i),
    .dreq         (dreq_o)
  );

  dma_mode_steer_ack u_ack (
    .clk     (clk),
    .rst     (rst),
    .dack_n  (dack_n_i),
    .cs_n    (cs_n_i),
    .accept  (accept),
    .conflict(conflict_o)
  );

  dma_mode_steer_route u_route (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .buf_dir(buf_dir_i),
    .accept (accept),
    .strobe (strobe)
  );

  assign enc_rd_o = strobe[PORT_ENC_RD];
  assign dec_wr_o = strobe[PORT_DEC_WR];
  assign buf_rd_o = strobe[PORT_BUF_RD];
  assign buf_wr_o = strobe[PORT_BUF_WR];

endmodule

// File: rtl/dma_mode_steer_chk.sv
module dma_mode_steer_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       buf_dir_i,
  input logic       enc_has_data_i,
  input logic       dec_has_space_i,
  input logic       buf_ready_i,
  input logic       dack_n_i,
  input logic       cs_n_i,
  input logic       dreq_o,
  input logic       enc_rd_o,
  input logic       dec_wr_o,
  input logic       buf_rd_o,
  input logic       buf_wr_o,
  input logic       conflict_o
);

  logic [3:0] strobes;
  assign strobes = {enc_rd_o, dec_wr_o, buf_rd_o, buf_wr_o};

  assert_req_code_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> (dreq_o == $past(enc_has_data_i)));

  assert_req_decode_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2) |=> (dreq_o == $past(dec_has_space_i)));

  assert_req_xfer_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd3) |=> (dreq_o == $past(buf_ready_i)));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> (!dreq_o && strobes == 4'b0000));

  assert_enc_route_R6: assert property (@(posedge clk) disable iff (rst)
    enc_rd_o |-> ($past(mode_i) == 2'd1 && !$past(dack_n_i)));

  assert_bufwr_route_R6: assert property (@(posedge clk) disable iff (rst)
    buf_wr_o |-> ($past(mode_i) == 2'd3 && $past(buf_dir_i)));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes != 4'b0000) |=> (strobes == 4'b0000));

  assert_clash_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (!dack_n_i && !cs_n_i) |=> (conflict_o && strobes == 4'b0000));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    conflict_o |=> conflict_o);

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

endmodule

bind dma_mode_steer dma_mode_steer_chk u_chk (.*);

// File: tb/dma_mode_steer_tb.sv
`timescale 1ns/1ps
module dma_mode_steer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       dir = 1'b0;
  logic       enc_ne = 1'b0, dec_sp = 1'b0, buf_rdy = 1'b0;
  logic       dack_n = 1'b1, cs_n = 1'b1;
  logic       dreq, enc_rd, dec_wr, buf_rd, buf_wr, conflict;

  int checks = 0;
  int errors = 0;
  int strobe_seen = 0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  dma_mode_steer u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .buf_dir_i(dir),
    .enc_has_data_i(enc_ne), .dec_has_space_i(dec_sp), .buf_ready_i(buf_rdy),
    .dack_n_i(dack_n), .cs_n_i(cs_n), .dreq_o(dreq),
    .enc_rd_o(enc_rd), .dec_wr_o(dec_wr), .buf_rd_o(buf_rd), .buf_wr_o(buf_wr),
    .conflict_o(conflict)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a strobe appears
  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] obs;
      obs = {enc_rd, dec_wr, buf_rd, buf_wr};
      if (obs != 4'b0000) begin
        strobe_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected strobe", int'(obs), 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(obs == e, "R6 strobe routing", int'(obs), int'(e));
        end
      end
    end
  end

  // Driver: one acknowledge assertion lasting hold cycles
  task automatic ack_pulse(input logic [1:0] m, input logic d, input int hold,
                           input bit with_cs);
    @(negedge clk);
    mode = m; dir = d; dack_n = 1'b0; cs_n = !with_cs;
    if (!with_cs) begin
      case (m)
        2'd1: exp_q.push_back(4'b1000);
        2'd2: exp_q.push_back(4'b0100);
        2'd3: exp_q.push_back(d ? 4'b0001 : 4'b0010);
        default: ;
      endcase
    end
    repeat (hold) @(negedge clk);
    dack_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic req_case(input logic [1:0] m, input logic e, input logic s,
                          input logic b, input logic exp, input string req);
    @(negedge clk);
    mode = m; enc_ne = e; dec_sp = s; buf_rdy = b;
    @(negedge clk);
    chk(dreq == exp, req, int'(dreq), int'(exp));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen_before;
    repeat (3) @(negedge clk);
    chk({dreq, enc_rd, dec_wr, buf_rd, buf_wr, conflict} == 6'b0, "R1 reset outputs",
        int'({dreq, enc_rd, dec_wr, buf_rd, buf_wr, conflict}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({dreq, conflict} == 2'b0, "R1 after reset", int'({dreq, conflict}), 0);

    // R2 coding request follows encoder flag, drops next cycle
    req_case(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, "R2 code request high");
    req_case(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 code request drops");
    // R3 decoding
    req_case(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R3 decode request high");
    req_case(2'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R3 decode request drops");
    // R4 transfer
    req_case(2'd3, 1'b0, 1'b0, 1'b1, 1'b1, "R4 xfer request high");
    req_case(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R4 xfer request drops");
    // R5 idle ignores all flags
    req_case(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R5 idle request low");

    // R6 routing in every mode and direction
    ack_pulse(2'd1, 1'b0, 1, 1'b0);
    ack_pulse(2'd2, 1'b0, 1, 1'b0);
    ack_pulse(2'd3, 1'b0, 1, 1'b0);
    ack_pulse(2'd3, 1'b1, 1, 1'b0);

    // R7 long acknowledge gives one pulse
    seen_before = strobe_seen;
    ack_pulse(2'd2, 1'b0, 6, 1'b0);
    chk(strobe_seen == seen_before + 1, "R7 one pulse per long ack",
        strobe_seen - seen_before, 1);

    // R5 idle acknowledge gives no strobe
    seen_before = strobe_seen;
    ack_pulse(2'd0, 1'b0, 2, 1'b0);
    chk(strobe_seen == seen_before, "R5 idle ack ignored", strobe_seen - seen_before, 0);

    // R8 conflict
    chk(conflict == 1'b0, "R8 flag clear before clash", int'(conflict), 0);
    seen_before = strobe_seen;
    ack_pulse(2'd1, 1'b0, 1, 1'b1);
    chk(strobe_seen == seen_before, "R8 clash suppressed", strobe_seen - seen_before, 0);
    chk(conflict == 1'b1, "R8 flag set", int'(conflict), 1);
    ack_pulse(2'd1, 1'b0, 1, 1'b0);
    chk(conflict == 1'b1, "R8 flag sticky", int'(conflict), 1);

    // R9 strobes never overlap across back-to-back modes
    ack_pulse(2'd3, 1'b1, 1, 1'b0);
    ack_pulse(2'd1, 1'b0, 1, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all expected strobes seen", exp_q.size(), 0);

    // R1 reset clears the sticky flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(conflict == 1'b0, "R1 reset clears flag", int'(conflict), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule